// File: doc/BRIEF.md
# Hot-plug slot event notifier

This block holds the slot control and slot status registers of a downstream port that supports hot-plug. It latches hardware event pulses (attention button, power fault, latch sensor change, presence change) and a command-completed event that it raises itself on each slot control write. From these registers it derives a single "notification pending" condition, which drives the port's interrupt.

The condition is true when the hot-plug interrupt enable is set and at least one latched event has its matching enable bit set. With message interrupts disabled, a level interrupt follows the condition directly. With message interrupts enabled, a one-cycle request pulse goes out only when the condition rises. An event latched while it was masked therefore interrupts at the moment software unmasks it. A slot reset strobe clears some status bits. A restore strobe loads a saved register image and rebuilds the stored condition without signalling anything.

Top module: `hp_slot_notifier`

## Requirements
- R1: After `rst_n` is low, `ctl_q`, `sta_q`, `intx` and `msi_req` are all zero.
- R2: The condition is `ctl[5] & |(ctl[4:0] & sta[4:0])`. Control bits 0..4 enable the status bits at the same positions: attention button 0, power fault 1, latch sensor 2, presence change 3, command completed 4. Bit 5 is the interrupt enable. While `msi_en` is 0, `intx` equals the condition registered at the last edge, so it falls when the condition falls.
- R3: While `msi_en` is 1, `intx` is 0. `msi_req` is high for the cycle whose clock edge makes the condition rise, and never on a fall.
- R4: An event that was latched while its enable bit or bit 5 was clear raises `intx` or `msi_req` in the cycle of the control write that enables it.
- R5: An event whose status bit is already set changes no register and produces no `msi_req`.
- R6: A status write (`wr_sel`=1) clears each of `sta[4:0]` where `wr_data` has a 1, and changes no other bit. A hardware event arriving in the same cycle stays set.
- R7: A control write with `wr_data[11]`=1 toggles the interlock status bit `sta[7]`. `ctl_q[11]` always reads 0. `ctl_q[10:0]` take `wr_data[10:0]`.
- R8: Every control write sets `sta[4]`. This happens after the condition has been evaluated with the new control value, so a fall-then-rise within that write cycle still issues `msi_req`.
- R9: A `slot_rst` pulse clears `sta[4]`, `sta[3]` and `sta[0]`, keeps every other bit, ignores the other inputs in that cycle and re-evaluates the condition.
- R10: A `restore` pulse, when `slot_rst` is low, loads `snap_ctl[10:0]`, `snap_sta[4:0]` and `snap_sta[7]`, and ignores writes and events in that cycle. The condition is rebuilt from the loaded image and `msi_req` stays 0.
- R11: Changing `msi_en` alone issues no `msi_req`. Clearing it while the condition is true makes `intx` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_abp | input | 1 | Attention button pulse |
| ev_pfd | input | 1 | Power fault pulse |
| ev_mrl | input | 1 | Latch sensor change pulse |
| ev_pdc | input | 1 | Presence change pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects slot control, 1 selects slot status |
| wr_data | input | 16 | Write data |
| msi_en | input | 1 | Message interrupts enabled |
| slot_rst | input | 1 | Slot reset strobe |
| restore | input | 1 | Restore strobe for the saved image |
| snap_ctl | input | 16 | Saved control image |
| snap_sta | input | 16 | Saved status image |
| ctl_q | output | 16 | Slot control readback |
| sta_q | output | 16 | Slot status readback |
| intx | output | 1 | Level interrupt |
| msi_req | output | 1 | One-cycle message interrupt request |

## Verification
Directed sequences cover four cases: an event latched while masked and unmasked later, a repeat of an event that is already pending, a control write that drops the condition and has the completion event raise it again, and switching `msi_en` while the condition is held. Each case separates edge signalling from level signalling, and separates the evaluation order inside a write cycle. Random traffic then mixes events, writes to both registers, slot resets and restores. A bench model that updates cycle by cycle compares each `msi_req` before the edge and each register and `intx` after it. This catches wrong clear masks, lost events and spurious pulses.

// File: rtl/hp_slot_notifier.sv
module hp_slot_notifier (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_abp,
  input  logic        ev_pfd,
  input  logic        ev_mrl,
  input  logic        ev_pdc,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  input  logic        msi_en,
  input  logic        slot_rst,
  input  logic        restore,
  input  logic [15:0] snap_ctl,
  input  logic [15:0] snap_sta,
  output logic [15:0] ctl_q,
  output logic [15:0] sta_q,
  output logic        intx,
  output logic        msi_req
);
  localparam int NEV = 5;
  localparam int CW  = 11;
  localparam logic [NEV-1:0] KEEP_ON_RST = 5'b00110;

  logic [CW-1:0]  ctl_r, ctl_a, ctl_n;
  logic [NEV-1:0] ev_r, ev_a, ev_f, ev_n;
  logic           eis_r, eis_n, note_r, note_n, mid, fin, pulse;

  function automatic logic cond_of(logic [CW-1:0] c, logic [NEV-1:0] s);
    return c[5] & (|(c[NEV-1:0] & s));
  endfunction

  wire wr_c = wr_en & ~wr_sel;
  wire wr_s = wr_en & wr_sel;

  assign ctl_a = wr_c ? wr_data[CW-1:0] : ctl_r;
  assign ev_a  = (wr_s ? (ev_r & ~wr_data[NEV-1:0]) : ev_r)
               | {1'b0, ev_pdc, ev_mrl, ev_pfd, ev_abp};
  assign mid   = cond_of(ctl_a, ev_a);
  assign ev_f  = ev_a | {wr_c, 4'b0};
  assign fin   = cond_of(ctl_a, ev_f);

  always_comb begin
    if (slot_rst) begin
      ctl_n  = ctl_r;
      ev_n   = ev_r & KEEP_ON_RST;
      eis_n  = eis_r;
      note_n = cond_of(ctl_r, ev_n);
      pulse  = msi_en & ~note_r & note_n;
    end else if (restore) begin
      ctl_n  = snap_ctl[CW-1:0];
      ev_n   = snap_sta[NEV-1:0];
      eis_n  = snap_sta[7];
      note_n = cond_of(ctl_n, ev_n);
      pulse  = 1'b0;
    end else begin
      ctl_n  = ctl_a;
      ev_n   = ev_f;
      eis_n  = eis_r ^ (wr_c & wr_data[11]);
      note_n = fin;
      pulse  = msi_en & ((~note_r & mid) | (~mid & fin));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_r  <= '0;
      ev_r   <= '0;
      eis_r  <= 1'b0;
      note_r <= 1'b0;
    end else begin
      ctl_r  <= ctl_n;
      ev_r   <= ev_n;
      eis_r  <= eis_n;
      note_r <= note_n;
    end
  end

  assign ctl_q   = {5'b0, ctl_r};
  assign sta_q   = {8'b0, eis_r, 2'b0, ev_r};
  assign intx    = ~msi_en & note_r;
  assign msi_req = pulse;
endmodule

// File: rtl/hp_slot_notifier_chk.sv
module hp_slot_notifier_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_abp,
  input logic        ev_pfd,
  input logic        ev_mrl,
  input logic        ev_pdc,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [15:0] wr_data,
  input logic        msi_en,
  input logic        slot_rst,
  input logic        restore,
  input logic [15:0] sta_q,
  input logic        msi_req
);
  wire calm = !slot_rst && !restore;

  p_msi_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> msi_en);

  p_repeat_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (calm && ev_abp && sta_q[0] && !ev_pfd && !ev_mrl && !ev_pdc && !wr_en) |-> !msi_req);

  p_event_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (calm && ev_abp) |=> sta_q[0]);

  p_interlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (calm && wr_en && !wr_sel && wr_data[11]) |=> (sta_q[7] != $past(sta_q[7])));

  p_cmd_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (calm && wr_en && !wr_sel) |=> sta_q[4]);

  p_slot_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rst |=> (sta_q[4:3] == 2'b00 && !sta_q[0]));

  p_restore_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (restore && !slot_rst) |-> !msi_req);
endmodule

bind hp_slot_notifier hp_slot_notifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_abp(ev_abp), .ev_pfd(ev_pfd), .ev_mrl(ev_mrl),
  .ev_pdc(ev_pdc), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .msi_en(msi_en), .slot_rst(slot_rst), .restore(restore), .sta_q(sta_q),
  .msi_req(msi_req)
);

// File: tb/sim_hp_slot_notifier.sv
module sim_hp_slot_notifier;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_abp = 0, ev_pfd = 0, ev_mrl = 0, ev_pdc = 0;
  logic wr_en = 0, wr_sel = 0, msi_en = 0, slot_rst = 0, restore = 0;
  logic [15:0] wr_data = '0, snap_ctl = '0, snap_sta = '0;
  logic [15:0] ctl_q, sta_q;
  logic intx, msi_req;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [10:0] m_ctl = '0;
  logic [4:0]  m_ev = '0;
  logic        m_eis = 0, m_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_slot_notifier u0 (.*);

  function automatic logic cond(logic [10:0] c, logic [4:0] s);
    return c[5] & (|(c[4:0] & s));
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step(input logic [3:0] ev, input logic we, input logic sel,
                      input logic [15:0] d, input logic me, input logic sr,
                      input logic rs, input logic [15:0] sc, input logic [15:0] ss,
                      input string tag);
    logic [10:0] nc, ca;
    logic [4:0] ne, ea;
    logic ni, nn, mid, emsi;
    @(negedge clk);
    {ev_pdc, ev_mrl, ev_pfd, ev_abp} = ev;
    wr_en = we; wr_sel = sel; wr_data = d; msi_en = me;
    slot_rst = sr; restore = rs; snap_ctl = sc; snap_sta = ss;
    if (sr) begin
      nc = m_ctl; ne = m_ev & 5'b00110; ni = m_eis; nn = cond(nc, ne);
      emsi = me & ~m_n & nn;
    end else if (rs) begin
      nc = sc[10:0]; ne = ss[4:0]; ni = ss[7]; nn = cond(nc, ne); emsi = 0;
    end else begin
      ca = (we && !sel) ? d[10:0] : m_ctl;
      ea = ((we && sel) ? (m_ev & ~d[4:0]) : m_ev) | {1'b0, ev};
      ni = m_eis ^ (we & ~sel & d[11]);
      mid = cond(ca, ea);
      ne = ea | {(we & ~sel), 4'b0};
      nc = ca; nn = cond(nc, ne);
      emsi = me & ((~m_n & mid) | (~mid & nn));
    end
    #1;
    chk(tag, "msi_req", msi_req, emsi);
    @(posedge clk);
    m_ctl = nc; m_ev = ne; m_eis = ni; m_n = nn;
    #1;
    chk(tag, "ctl_q", ctl_q, {5'b0, m_ctl});
    chk(tag, "sta_q", sta_q, {8'b0, m_eis, 2'b0, m_ev});
    chk(tag, "intx", intx, ~me & m_n);
  endtask

  task automatic wc(input logic [15:0] d, input logic me, input string tag);
    step(4'b0, 1, 0, d, me, 0, 0, 0, 0, tag);
  endtask
  task automatic ws(input logic [15:0] d, input logic me, input string tag);
    step(4'b0, 1, 1, d, me, 0, 0, 0, 0, tag);
  endtask
  task automatic ev1(input logic [3:0] e, input logic me, input string tag);
    step(e, 0, 0, 0, me, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #(CLK_PERIOD * 3);
    chk("R1", "ctl_q", ctl_q, 0);
    chk("R1", "sta_q", sta_q, 0);
    chk("R1", "intx", intx, 0);
    chk("R1", "msi_req", msi_req, 0);
    @(negedge clk); rst_n = 1;

    // R4 masked event, unmasked later (level mode)
    wc(16'h0020, 0, "R4");
    ev1(4'b0001, 0, "R4");
    chk("R4", "intx masked", intx, 0);
    wc(16'h0021, 0, "R4");
    chk("R4", "intx unmasked", intx, 1);
    // R5 repeat of pending event
    ev1(4'b0001, 0, "R5");
    // R2 condition falls via W1C, intx drops
    ws(16'h0001, 0, "R2");
    chk("R2", "intx after clear", intx, 0);
    // R4 message mode, unmask fires request
    ws(16'h001F, 1, "R6");
    wc(16'h0022, 1, "R4");
    ev1(4'b0001, 1, "R4");
    step(4'b0, 1, 0, 16'h0023, 1, 0, 0, 0, 0, "R4");
    // R5 repeated identical event, no pulse
    ev1(4'b0001, 1, "R5");
    ev1(4'b0001, 1, "R5");
    // R8 dip: clear completion, then write dropping ABE but enabling completion
    ws(16'h0010, 1, "R8");
    step(4'b0, 1, 0, 16'h0030, 1, 0, 0, 0, 0, "R8");
    // R11 msi_en toggling with condition true
    ev1(4'b0, 0, "R11");
    chk("R11", "intx level", intx, 1);
    ev1(4'b0, 1, "R11");
    // R7 interlock toggle twice
    wc(16'h0830, 1, "R7");
    wc(16'h0830, 1, "R7");
    // R6 W1C with same-cycle event
    step(4'b0001, 1, 1, 16'h00FF, 1, 0, 0, 0, 0, "R6");
    // R9 slot reset
    ev1(4'b1110, 1, "R9");
    step(4'b1111, 1, 0, 16'h0FFF, 1, 1, 0, 0, 0, "R9");
    // R10 restore silent
    step(4'b0, 0, 0, 0, 1, 0, 1, 16'h0021, 16'h0081, "R10");
    ev1(4'b0, 0, "R10");

    for (int i = 0; i < 1500; i++) begin
      logic [3:0] e;
      logic [15:0] d;
      logic we, sel, sr, rs;
      e = {($urandom % 8 == 0), ($urandom % 8 == 0), ($urandom % 8 == 0), ($urandom % 8 == 0)};
      we = ($urandom % 4 == 0);
      sel = $urandom % 2;
      d = 16'($urandom);
      if (!sel && ($urandom % 4 != 0)) d[5] = 1'b1;
      if ($urandom % 32 == 0) msi_en = ~msi_en;
      sr = ($urandom % 64 == 0);
      rs = ($urandom % 64 == 0);
      step(e, we, sel, d, msi_en, sr, rs, 16'($urandom), 16'($urandom), "R2 R3");
    end
    finish_run();
  end
endmodule